// File: doc/BRIEF.md
# Eight-Line Prioritized Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt output plus an 8-bit vector to a processor. A rising edge on a line latches a pending request. The controller picks the pending, unmasked request with the best priority. It raises its output only when that request outranks every request already being serviced. An acknowledge pulse moves the chosen request into service and publishes its vector.

Software reaches the block through two addresses selected by one address bit. The command address (`addr_sel` = 0) takes initialization starts and operational commands, and reads back the pending or in-service register. The data address (`addr_sel` = 1) takes the remaining initialization words and, once the sequencer is idle, reads and writes the line mask. End of service is signalled by a command, either for all in-service lines at once or for one named line.

Top module: `pic_core`

## Requirements
- R1: After reset the mask is 0xFF, the pending and in-service registers are 0, the command-address readback shows the pending register, the sequencer is idle (a data-address write loads the mask), and `irq_out` is 0.
- R2: A 0-to-1 transition on `irq_lines[n]` sets pending bit n one clock later. A line held high does not set the bit again after that bit has been cleared.
- R3: Mask bit n = 1 blocks line n from `irq_out`. While the sequencer is idle, a data-address write loads the mask and a data-address read returns it.
- R4: Line 0 has the highest priority and line 7 the lowest. `irq_out` is 1 exactly when some unmasked pending line has a lower index than every in-service line.
- R5: `ack` while `irq_out` is 1 clears the winning pending bit n, sets in-service bit n and, from the next cycle, drives `vector` = base | n. `ack` while `irq_out` is 0 has no effect.
- R6: A command-address write with bit 4 = 1 starts initialization. The next data-address write sets the vector base to that data AND 0xF8.
- R7: In the start word, bit 0 = 1 means a fourth word follows. The third word is ignored. Words written during initialization do not change the mask, and the first data-address write after the last word loads the mask.
- R8: A command-address write with bit 4 = 0 during initialization ends it, so the next data-address write loads the mask.
- R9: Command 0x0A selects the pending register and 0x0B selects the in-service register for command-address reads.
- R10: Command 0x20 clears all in-service bits and clears the pending bits that were in service.
- R11: Command 0x60|n (n = 0..7) clears bit n of both the in-service and the pending register.
- R12: Commands 0x68 and 0xC0 to 0xC7, and any other code with bit 4 = 0 not listed above, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | 0 = command address, 1 = data address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_lines | input | 8 | Interrupt request lines, edge-sensitive |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last acknowledged line |

## Verification
The priority logic is exercised with two simultaneous requests, which shows that the lower index wins. A later, higher-priority request arriving while a lower one is in service shows nesting. A lower-priority request behind an in-service line shows blocking. Masking a sole pending line separates the mask path from the in-service comparison. A line held high after its bit is cleared separates edge detection from level detection. Initialization is run with and without the fourth word and is aborted part-way, and each run is judged by whether a later data write lands in the mask.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  // lowest set bit as a one-hot value (0 when none set)
  function automatic logic [LINES-1:0] low_onehot(input logic [LINES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // lines strictly better than the best in-service line (all ones when none)
  function automatic logic [LINES-1:0] outranks(input logic [LINES-1:0] svc);
    return low_onehot(svc) - 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] oh_index(input logic [LINES-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LINES; i++)
      if (oh[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic is_spec_eoi(input logic [7:0] c);
    return c[7:3] == 5'b01100;
  endfunction
endpackage

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [LINES-1:0] mask_q,
  output logic [DW-1:0]    vbase_q,
  output logic             sel_svc_q,
  output logic             ns_eoi,
  output logic             sp_eoi,
  output logic [IDX_W-1:0] sp_line
);
  localparam logic [DW-1:0] BASE_KEEP = ~DW'(LINES - 1);

  seq_t seq_q;
  logic four_q;
  logic cmd_wr, init_wr, data_wr;

  assign init_wr = wr_en && !addr_sel && wdata[4];
  assign cmd_wr  = wr_en && !addr_sel && !wdata[4];
  assign data_wr = wr_en && addr_sel;
  assign ns_eoi  = cmd_wr && (wdata == 8'h20);
  assign sp_eoi  = cmd_wr && is_spec_eoi(wdata);
  assign sp_line = wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q     <= SEQ_IDLE;
      four_q    <= 1'b0;
      mask_q    <= '1;
      vbase_q   <= '0;
      sel_svc_q <= 1'b0;
    end else if (init_wr) begin
      seq_q  <= SEQ_BASE;
      four_q <= wdata[0];
    end else if (cmd_wr) begin
      seq_q <= SEQ_IDLE;
      if (wdata == 8'h0A) sel_svc_q <= 1'b0;
      else if (wdata == 8'h0B) sel_svc_q <= 1'b1;
    end else if (data_wr) begin
      unique case (seq_q)
        SEQ_BASE: begin
          vbase_q <= wdata & BASE_KEEP;
          seq_q   <= SEQ_CASC;
        end
        SEQ_CASC: seq_q <= four_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: seq_q <= SEQ_IDLE;
        default:  mask_q <= wdata[LINES-1:0];
      endcase
    end
  end

  a_r6_init_start: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> seq_q == SEQ_BASE);
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> seq_q == SEQ_IDLE);
  a_r7_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q != SEQ_IDLE) |=> $stable(mask_q));
endmodule

// File: rtl/pic_req_regs.sv
module pic_req_regs
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic             ack_take,
  input  logic [LINES-1:0] win_oh,
  input  logic             ns_eoi,
  input  logic             sp_eoi,
  input  logic [IDX_W-1:0] sp_line,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] svc_q
);
  logic [LINES-1:0] prev_q, rise, pend_n, svc_n, sp_clr;

  assign rise   = lines & ~prev_q;
  assign sp_clr = sp_eoi ? (LINES'(1) << sp_line) : '0;

  always_comb begin
    pend_n = pend_q;
    svc_n  = svc_q;
    if (ack_take) begin
      pend_n = pend_n & ~win_oh;
      svc_n  = svc_n | win_oh;
    end
    if (ns_eoi) begin
      pend_n = pend_n & ~svc_q;
      svc_n  = '0;
    end
    pend_n = (pend_n & ~sp_clr) | rise;
    svc_n  = svc_n & ~sp_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      prev_q <= lines;
      pend_q <= pend_n;
      svc_q  <= svc_n;
    end
  end

  a_r5_ack_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !ns_eoi && !sp_eoi |=> (svc_q & $past(win_oh)) != '0);
  a_r10_ns_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ns_eoi && !ack_take |=> svc_q == '0);
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> (pend_q & $past(rise)) == $past(rise));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pend_q,
  input  logic [LINES-1:0] svc_q,
  input  logic [LINES-1:0] mask_q,
  input  logic [DW-1:0]    vbase_q,
  input  logic             ack,
  output logic             irq_out,
  output logic             ack_take,
  output logic [LINES-1:0] win_oh,
  output logic [DW-1:0]    vector_q
);
  logic [LINES-1:0] live;
  logic [IDX_W-1:0] win_idx;

  assign live     = pend_q & ~mask_q;
  assign win_oh   = low_onehot(live);
  assign win_idx  = oh_index(win_oh);
  assign irq_out  = (win_oh & outranks(svc_q)) != '0;
  assign ack_take = ack && irq_out;

  always_ff @(posedge clk) begin
    if (!rst_n) vector_q <= '0;
    else if (ack_take) vector_q <= vbase_q | DW'(win_idx);
  end

  a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q & ~mask_q) != '0);
  a_r4_outranks_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_oh & svc_q) == '0);
  a_r5_vector_line: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> vector_q[IDX_W-1:0] == $past(win_idx));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_lines,
  input  logic       ack,
  output logic       irq_out,
  output logic [7:0] vector
);
  logic [LINES-1:0] mask_q, pend_q, svc_q, win_oh;
  logic [7:0]       vbase_q;
  logic             sel_svc_q, ns_eoi, sp_eoi, ack_take;
  logic [IDX_W-1:0] sp_line;

  pic_cmd_port #(.DW(8)) u_port (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
    .wdata(wdata), .mask_q(mask_q), .vbase_q(vbase_q),
    .sel_svc_q(sel_svc_q), .ns_eoi(ns_eoi), .sp_eoi(sp_eoi),
    .sp_line(sp_line)
  );

  pic_req_regs u_regs (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .ack_take(ack_take),
    .win_oh(win_oh), .ns_eoi(ns_eoi), .sp_eoi(sp_eoi), .sp_line(sp_line),
    .pend_q(pend_q), .svc_q(svc_q)
  );

  pic_resolver #(.DW(8)) u_res (
    .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .svc_q(svc_q),
    .mask_q(mask_q), .vbase_q(vbase_q), .ack(ack), .irq_out(irq_out),
    .ack_take(ack_take), .win_oh(win_oh), .vector_q(vector)
  );

  always_comb begin
    if (!rd_en)        rdata = '0;
    else if (addr_sel) rdata = mask_q;
    else if (sel_svc_q) rdata = svc_q;
    else               rdata = pend_q;
  end

  a_r1_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/pic_core_tb.sv
module pic_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_lines = '0;
  logic [7:0] rdata, vector;
  logic       irq_out;
  int         n_chk = 0, n_bad = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  pic_core dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines),
    .ack(ack), .irq_out(irq_out), .vector(vector)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk); addr_sel = a; rd_en = 1'b1;
    it.exp = exp; it.tag = tag; sb_q.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_lines(input logic [7:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin n_chk++; n_bad++; $display("FAIL scoreboard left=%0d expected=0", sb_q.size()); end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: pops one expected item for every read cycle
  always @(posedge clk) begin
    #2;
    if (rd_en) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++; $display("FAIL monitor: read with empty queue actual=%02h expected=none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rd(1'b0, 8'h00, "R1 pending");
    rd(1'b1, 8'hFF, "R1 mask");
    // R6/R7 init with fourth word; base low bits dropped
    wr(1'b0, 8'h11); wr(1'b1, 8'h27); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, 8'hFF, "R7 mask untouched by init words");
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h00, "R3 mask readback");
    // R2/R4 two requests
    set_lines(8'h28);
    rd(1'b0, 8'h28, "R2 edges latched");
    check("R4 irq_out asserted", {7'd0, irq_out}, 8'h01);
    pulse_ack();
    check("R5/R6 vector", vector, 8'h23);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R9 service readback");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R5 pending cleared");
    check("R4 blocked by service", {7'd0, irq_out}, 8'h00);
    pulse_ack();
    check("R5 ack ignored when idle", vector, 8'h23);
    // nesting
    set_lines(8'h2A);
    check("R4 nesting", {7'd0, irq_out}, 8'h01);
    pulse_ack();
    check("R5 nested vector", vector, 8'h21);
    // R11 specific end
    wr(1'b0, 8'h61);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R11 service bit1 cleared");
    // R12 no-effect commands
    wr(1'b0, 8'h68); wr(1'b0, 8'hC3); wr(1'b0, 8'h0C);
    rd(1'b0, 8'h08, "R12 service unchanged");
    rd(1'b1, 8'h00, "R12 mask unchanged");
    // R10 non-specific end with line3 pending again
    set_lines(8'h00);
    set_lines(8'h08);
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R10 service cleared");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R10 pending of serviced line cleared");
    check("R4 lone request", {7'd0, irq_out}, 8'h01);
    wr(1'b1, 8'h20);
    check("R3 mask blocks", {7'd0, irq_out}, 8'h00);
    wr(1'b1, 8'h00);
    check("R3 unmask", {7'd0, irq_out}, 8'h01);
    // R8 abort
    wr(1'b0, 8'h13); wr(1'b0, 8'h0A); wr(1'b1, 8'h5A);
    rd(1'b1, 8'h5A, "R8 abort then mask write");
    // R7 init without fourth word
    wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h0F);
    rd(1'b1, 8'h0F, "R7 three-word init then mask");
    pulse_ack();
    check("R6 new base vector", vector, 8'h45);
    wr(1'b0, 8'h65);
    // R2 held level does not refire
    set_lines(8'h48);
    pulse_ack();
    check("R5 line6 vector", vector, 8'h46);
    wr(1'b0, 8'h66);
    repeat (2) @(negedge clk);
    rd(1'b0, 8'h00, "R2 held line no refire");
    check("R2 irq_out low", {7'd0, irq_out}, 8'h00);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule